// File: doc/BRIEF.md
# Virtual Address Fault Checker

This block sits between a processor's address generation and its memory port. Each cycle it may accept one 32-bit access, described by a virtual address, an access kind (data read, data write or instruction fetch) and a privilege flag. A fixed address map picks one of three paths. The first is a supervisor bypass window, where physical equals virtual. The second is a privileged window that user code may not touch. The third is translation through a small fully associative TLB. The block answers one cycle later with a done strobe, a fault flag, a cause code and the physical address.

TLB entries are written by index through a load port. A fault updates three architectural registers. The bad-address register always takes the faulting address. For translation faults only, the page-table-address register takes a new page-number field and the data/instruction flag is set or cleared. The base field of the page-table-address register changes only through its own load port. A parameter can remove translation entirely, and the block then maps every access by identity.

Control is a two-state machine. `ST_IDLE` is the state after reset and whenever no request arrived in the previous cycle. `ST_DONE` is the state for the cycle after any accepted request. The named transitions are: IDLE→DONE on request valid, DONE→DONE on a back-to-back request, and DONE→IDLE when no request arrives.

Top module: `vaddr_fault_unit`

## Requirements
- R1: With the supervisor flag set, an address at or above 0xC000_0000 is not translated. It returns physical = virtual with no fault, and the bad-address, page-table-address and data-flag registers keep their values.
- R2: With the supervisor flag set, an address below 0xC000_0000 is translated through the TLB. With the flag clear, an address below 0x8000_0000 is translated through the TLB.
- R3: With the supervisor flag clear, an address at or above 0x8000_0000 faults with cause 5 and loads the bad-address register with the address. No TLB lookup is made, and the page-table-address register and data flag are unchanged.
- R4: A translated access that matches no valid entry faults with cause 1.
- R5: Entry permission bits are bit 0 read, bit 1 write and bit 2 execute. The access kind is encoded as 0 read, 1 write, 2 fetch, and 3 is treated as read. A hit whose needed bit is clear faults with cause 2 for a read, cause 3 for a write and cause 4 for a fetch.
- R6: On a translation fault (cause 1 to 4), the data flag is cleared for a fetch and set for a read or write, and the bad-address register takes the address.
- R7: The page-table-address register holds the base in bits [31:22], the page number in bits [21:2] and zero in bits [1:0]. A translation fault writes address bits [31:12] into bits [21:2] and leaves the base. Only the base load port changes the base.
- R8: On a hit with the needed permission, the physical address is the entry's 20-bit frame number followed by address bits [11:0], with no fault (cause 0). If several valid entries match, the lowest index wins.
- R9: The done strobe is high exactly in the cycle after each cycle with request valid high, and back-to-back requests give back-to-back results.
- R10: With the MMU parameter off, every access returns physical = virtual with no fault, whatever its privilege or region.
- R11: After reset, all outputs and registers are zero and every TLB entry is invalid.
- R12: A write through the load port replaces the entry at that index, and the new entry is used from the next request on. This includes clearing the valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_super | input | 1 | Supervisor privilege |
| tlb_we | input | 1 | Load one TLB entry |
| tlb_idx | input | 3 | Entry index to load |
| tlb_valid | input | 1 | Valid bit for the loaded entry |
| tlb_vpn | input | 20 | Virtual page number for the loaded entry |
| tlb_pfn | input | 20 | Physical frame number for the loaded entry |
| tlb_perm | input | 3 | Permission bits {X,W,R} |
| base_we | input | 1 | Load the page-table base field |
| base_in | input | 10 | New base field value |
| rsp_done | output | 1 | Result valid |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 3 | Cause code, 0 when no fault |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| badaddr | output | 32 | Last faulting address |
| pteaddr | output | 32 | Base, faulting page number, two zero bits |
| data_flag | output | 1 | 1 when the last translation fault was a data access |

## Verification
Addresses are taken on both sides of each map boundary (0x7FFF_FFFF/0x8000_0000 and 0xBFFF_FFFF/0xC000_0000) under both privilege flags. This separates the bypass, translated and privileged-fault paths. Each entry's permissions are probed with all three access kinds and with the reserved kind, so a wrong cause mapping or a wrong permission-bit choice shows up as a distinct cause. Two valid entries map the same page, and the lower one is later invalidated, which shows whether the lowest index wins and whether a load takes effect. A second instance built with translation off gets the same stream of accesses, and its outputs must stay identity with no fault.

// File: rtl/vfu_pkg.sv
package vfu_pkg;
    localparam int VA_W    = 32;
    localparam int PG_BITS = 12;
    localparam int VPN_W   = VA_W - PG_BITS;
    localparam int PFN_W   = 20;
    localparam int BASE_W  = 10;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        CZ_NONE       = 3'd0,
        CZ_TLB_MISS   = 3'd1,
        CZ_DENY_RD    = 3'd2,
        CZ_DENY_WR    = 3'd3,
        CZ_DENY_EX    = 3'd4,
        CZ_SUPER_ONLY = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_XLATE,
        PATH_PRIV_FAULT
    } path_e;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } st_e;
endpackage

// File: rtl/vfu_region_decode.sv
module vfu_region_decode
    import vfu_pkg::*;
#(
    parameter bit            MMU_EN      = 1'b1,
    parameter logic [31:0]   BYPASS_BASE = 32'hC000_0000,
    parameter logic [31:0]   USER_LIMIT  = 32'h8000_0000
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            super_mode,
    output path_e           path
);
    always_comb begin
        if (!MMU_EN) begin
            path = PATH_BYPASS;
        end else if (super_mode) begin
            path = (vaddr >= BYPASS_BASE) ? PATH_BYPASS : PATH_XLATE;
        end else begin
            path = (vaddr >= USER_LIMIT) ? PATH_PRIV_FAULT : PATH_XLATE;
        end
    end
endmodule

// File: rtl/vfu_tlb.sv
module vfu_tlb
    import vfu_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic                       wr_valid,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic [PFN_W-1:0]           wr_pfn,
    input  logic [2:0]                 wr_perm,
    input  logic [VPN_W-1:0]           lk_vpn,
    output logic                       lk_hit,
    output logic [PFN_W-1:0]           lk_pfn,
    output logic [2:0]                 lk_perm
);
    logic               e_valid [ENTRIES];
    logic [VPN_W-1:0]   e_vpn   [ENTRIES];
    logic [PFN_W-1:0]   e_pfn   [ENTRIES];
    logic [2:0]         e_perm  [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                e_valid[i] <= 1'b0;
                e_vpn[i]   <= '0;
                e_pfn[i]   <= '0;
                e_perm[i]  <= '0;
            end else if (wr_en && (wr_idx == i[$clog2(ENTRIES)-1:0])) begin
                e_valid[i] <= wr_valid;
                e_vpn[i]   <= wr_vpn;
                e_pfn[i]   <= wr_pfn;
                e_perm[i]  <= wr_perm;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = e_valid[g] && (e_vpn[g] == lk_vpn);
    end

    // lowest index wins: scan downward so the last hit assigned is the lowest
    always_comb begin
        lk_hit  = 1'b0;
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit  = 1'b1;
                lk_pfn  = e_pfn[i];
                lk_perm = e_perm[i];
            end
        end
    end

    p_hit_iff_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit == (match != '0));
endmodule

// File: rtl/vfu_fault_regs.sv
module vfu_fault_regs
    import vfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_bad,
    input  logic              upd_xlate,
    input  logic [VA_W-1:0]   vaddr,
    input  logic              is_fetch,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_in,
    output logic [VA_W-1:0]   badaddr,
    output logic [31:0]       pteaddr,
    output logic              data_flag
);
    logic [BASE_W-1:0] base_q;
    logic [VPN_W-1:0]  vpn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            badaddr   <= '0;
            base_q    <= '0;
            vpn_q     <= '0;
            data_flag <= 1'b0;
        end else begin
            if (upd_bad) badaddr <= vaddr;
            if (base_we) base_q <= base_in;
            if (upd_xlate) begin
                vpn_q     <= vaddr[VA_W-1:PG_BITS];
                data_flag <= !is_fetch;
            end
        end
    end

    assign pteaddr = {base_q, vpn_q, 2'b00};

    p_base_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !base_we |=> pteaddr[31:22] == $past(pteaddr[31:22]));

    p_vpn_loaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_xlate |=> pteaddr[21:2] == $past(vaddr[31:12]));

    p_flag_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_xlate |=> data_flag == !$past(is_fetch));

    p_priv_leaves_pte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_bad && !upd_xlate && !base_we) |=> $stable(pteaddr) && $stable(data_flag));
endmodule

// File: rtl/vaddr_fault_unit.sv
module vaddr_fault_unit
    import vfu_pkg::*;
#(
    parameter int TLB_ENTRIES = 8,
    parameter bit MMU_EN      = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [31:0]                    req_vaddr,
    input  logic [1:0]                     req_kind,
    input  logic                           req_super,
    input  logic                           tlb_we,
    input  logic [$clog2(TLB_ENTRIES)-1:0] tlb_idx,
    input  logic                           tlb_valid,
    input  logic [19:0]                    tlb_vpn,
    input  logic [19:0]                    tlb_pfn,
    input  logic [2:0]                     tlb_perm,
    input  logic                           base_we,
    input  logic [9:0]                     base_in,
    output logic                           rsp_done,
    output logic                           rsp_fault,
    output logic [2:0]                     rsp_cause,
    output logic [31:0]                    rsp_paddr,
    output logic [31:0]                    badaddr,
    output logic [31:0]                    pteaddr,
    output logic                           data_flag
);
    st_e          state, state_nx;
    path_e        path;
    logic         hit;
    logic [19:0]  hit_pfn;
    logic [2:0]   hit_perm;
    logic         need_ok;
    cause_e       deny_cause;
    logic         c_fault;
    cause_e       c_cause;
    logic [31:0]  c_paddr;
    logic         is_fetch;

    vfu_region_decode #(.MMU_EN(MMU_EN)) u_region (
        .vaddr      (req_vaddr),
        .super_mode (req_super),
        .path       (path)
    );

    vfu_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tlb_we),
        .wr_idx   (tlb_idx),
        .wr_valid (tlb_valid),
        .wr_vpn   (tlb_vpn),
        .wr_pfn   (tlb_pfn),
        .wr_perm  (tlb_perm),
        .lk_vpn   (req_vaddr[31:12]),
        .lk_hit   (hit),
        .lk_pfn   (hit_pfn),
        .lk_perm  (hit_perm)
    );

    assign is_fetch = (req_kind == ACC_FETCH);

    always_comb begin
        unique case (acc_e'(req_kind))
            ACC_WRITE: begin need_ok = hit_perm[1]; deny_cause = CZ_DENY_WR; end
            ACC_FETCH: begin need_ok = hit_perm[2]; deny_cause = CZ_DENY_EX; end
            default:   begin need_ok = hit_perm[0]; deny_cause = CZ_DENY_RD; end
        endcase
    end

    always_comb begin
        c_fault = 1'b0;
        c_cause = CZ_NONE;
        c_paddr = req_vaddr;
        unique case (path)
            PATH_BYPASS: ;
            PATH_PRIV_FAULT: begin
                c_fault = 1'b1;
                c_cause = CZ_SUPER_ONLY;
                c_paddr = '0;
            end
            PATH_XLATE: begin
                if (!hit) begin
                    c_fault = 1'b1;
                    c_cause = CZ_TLB_MISS;
                    c_paddr = '0;
                end else if (!need_ok) begin
                    c_fault = 1'b1;
                    c_cause = deny_cause;
                    c_paddr = '0;
                end else begin
                    c_paddr = {hit_pfn, req_vaddr[11:0]};
                end
            end
            default: ;
        endcase
    end

    vfu_fault_regs u_fregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_bad   (req_valid && c_fault),
        .upd_xlate (req_valid && c_fault && (path == PATH_XLATE)),
        .vaddr     (req_vaddr),
        .is_fetch  (is_fetch),
        .base_we   (base_we),
        .base_in   (base_in),
        .badaddr   (badaddr),
        .pteaddr   (pteaddr),
        .data_flag (data_flag)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nx = req_valid ? ST_DONE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
        end else if (req_valid) begin
            rsp_fault <= c_fault;
            rsp_cause <= c_cause;
            rsp_paddr <= c_paddr;
        end
    end

    assign rsp_done = (state == ST_DONE);

    p_done_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    p_no_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done);

    p_user_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (MMU_EN && req_valid && !req_super && req_vaddr[31]) |=>
            (rsp_fault && rsp_cause == CZ_SUPER_ONLY && badaddr == $past(req_vaddr)));

    p_bypass_ident_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_super && req_vaddr >= 32'hC000_0000) |=>
            (!rsp_fault && rsp_paddr == $past(req_vaddr)));

    p_off_no_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!MMU_EN && req_valid) |=> (!rsp_fault && rsp_paddr == $past(req_vaddr)));

    p_cause_iff_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_fault == (rsp_cause != 3'd0)));
endmodule

// File: tb/tb_vaddr_fault_unit.sv
`timescale 1ns/1ps
module tb_vaddr_fault_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic        tlb_we = 1'b0;
    logic [2:0]  tlb_idx = '0;
    logic        tlb_valid = 1'b0;
    logic [19:0] tlb_vpn = '0;
    logic [19:0] tlb_pfn = '0;
    logic [2:0]  tlb_perm = '0;
    logic        base_we = 1'b0;
    logic [9:0]  base_in = '0;

    logic        rsp_done, rsp_fault, data_flag;
    logic [2:0]  rsp_cause;
    logic [31:0] rsp_paddr, badaddr, pteaddr;
    logic        n_done, n_fault, n_flag;
    logic [2:0]  n_cause;
    logic [31:0] n_paddr, n_bad, n_pte;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vaddr_fault_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_super(req_super), .tlb_we(tlb_we), .tlb_idx(tlb_idx),
        .tlb_valid(tlb_valid), .tlb_vpn(tlb_vpn), .tlb_pfn(tlb_pfn), .tlb_perm(tlb_perm),
        .base_we(base_we), .base_in(base_in), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .badaddr(badaddr),
        .pteaddr(pteaddr), .data_flag(data_flag)
    );

    vaddr_fault_unit #(.MMU_EN(1'b0)) dut_nommu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_super(req_super), .tlb_we(tlb_we), .tlb_idx(tlb_idx),
        .tlb_valid(tlb_valid), .tlb_vpn(tlb_vpn), .tlb_pfn(tlb_pfn), .tlb_perm(tlb_perm),
        .base_we(base_we), .base_in(base_in), .rsp_done(n_done), .rsp_fault(n_fault),
        .rsp_cause(n_cause), .rsp_paddr(n_paddr), .badaddr(n_bad),
        .pteaddr(n_pte), .data_flag(n_flag)
    );

    // behavioural reference state
    bit          m_val  [8];
    logic [19:0] m_vpn  [8];
    logic [19:0] m_pfn  [8];
    logic [2:0]  m_perm [8];
    logic [9:0]  m_base = '0;
    logic [19:0] m_vpnf = '0;
    logic [31:0] m_bad  = '0;
    bit          m_flag = 1'b0;

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic check_regs(string tag);
        check(tag, "badaddr", badaddr, m_bad);
        check(tag, "pteaddr", pteaddr, {m_base, m_vpnf, 2'b00});
        check(tag, "data_flag", {31'd0, data_flag}, {31'd0, m_flag});
    endtask

    // one access; called at a falling edge, returns at the next one
    task automatic access(string tag, bit sup, logic [31:0] va, logic [1:0] kind);
        int  e_cause = 0;
        logic [31:0] e_pa = va;
        int  idx = -1;
        bit  allowed;
        if (sup && va >= 32'hC000_0000) begin
            e_cause = 0;
        end else if (!sup && va >= 32'h8000_0000) begin
            e_cause = 5;
            m_bad = va;
        end else begin
            for (int i = 7; i >= 0; i--)
                if (m_val[i] && m_vpn[i] == va[31:12]) idx = i;
            if (idx < 0) e_cause = 1;
            else begin
                allowed = (kind == 2'd1) ? m_perm[idx][1] :
                          (kind == 2'd2) ? m_perm[idx][2] : m_perm[idx][0];
                if (!allowed) e_cause = (kind == 2'd1) ? 3 : (kind == 2'd2) ? 4 : 2;
                else e_pa = {m_pfn[idx], va[11:0]};
            end
            if (e_cause != 0) begin
                m_bad  = va;
                m_vpnf = va[31:12];
                m_flag = (kind != 2'd2);
            end
        end
        if (e_cause != 0) e_pa = '0;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "done", {31'd0, rsp_done}, 32'd1);
        check(tag, "fault", {31'd0, rsp_fault}, (e_cause != 0) ? 32'd1 : 32'd0);
        check(tag, "cause", {29'd0, rsp_cause}, e_cause);
        check(tag, "paddr", rsp_paddr, e_pa);
        check_regs(tag);
        check("R10", "nommu fault", {31'd0, n_fault}, 32'd0);
        check("R10", "nommu paddr", n_paddr, va);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        check(tag, "done idle", {31'd0, rsp_done}, 32'd0);
        check(tag, "nommu done idle", {31'd0, n_done}, 32'd0);
    endtask

    task automatic load(int idx, bit v, logic [19:0] vpn, logic [19:0] pfn, logic [2:0] perm);
        tlb_we = 1'b1; tlb_idx = idx[2:0]; tlb_valid = v;
        tlb_vpn = vpn; tlb_pfn = pfn; tlb_perm = perm;
        @(negedge clk);
        tlb_we = 1'b0;
        m_val[idx] = v; m_vpn[idx] = vpn; m_pfn[idx] = pfn; m_perm[idx] = perm;
        check("R9", "done on load", {31'd0, rsp_done}, 32'd0);
    endtask

    task automatic set_base(logic [9:0] b);
        base_we = 1'b1; base_in = b;
        @(negedge clk);
        base_we = 1'b0;
        m_base = b;
        check_regs("R7");
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_val[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11", "done", {31'd0, rsp_done}, 32'd0);
        check("R11", "fault", {31'd0, rsp_fault}, 32'd0);
        check("R11", "paddr", rsp_paddr, 32'd0);
        check_regs("R11");
        access("R11", 1'b0, 32'h0001_0ABC, 2'd0);  // empty TLB misses
        access("R11", 1'b1, 32'h9000_0000, 2'd2);

        // R12: entry loads, including a duplicate page
        load(0, 1'b1, 20'h00010, 20'hABCDE, 3'b011);
        load(1, 1'b1, 20'h90000, 20'h12345, 3'b100);
        load(2, 1'b1, 20'h00020, 20'h55555, 3'b111);
        load(3, 1'b1, 20'h00020, 20'h66666, 3'b111);
        set_base(10'h2A5);

        // R8 / R2: hits
        access("R8", 1'b0, 32'h0001_0ABC, 2'd0);
        access("R2", 1'b1, 32'h0001_0FFF, 2'd1);
        access("R2", 1'b1, 32'h9000_0010, 2'd2);
        access("R5", 1'b0, 32'h0001_0004, 2'd3);   // reserved kind = read
        access("R8", 1'b0, 32'h0002_0123, 2'd1);   // lowest index wins

        // R5 / R6 / R7: permission faults
        access("R5", 1'b0, 32'h0001_0000, 2'd2);
        access("R6", 1'b1, 32'h9000_0004, 2'd0);
        access("R5", 1'b1, 32'h9000_0008, 2'd1);
        access("R5", 1'b1, 32'h9000_0008, 2'd3);

        // R1: bypass window
        access("R1", 1'b1, 32'hC000_0000, 2'd0);
        access("R1", 1'b1, 32'hFFFF_FFFC, 2'd2);
        access("R1", 1'b1, 32'hC000_1234, 2'd1);

        // R3: user access to privileged window
        access("R3", 1'b0, 32'h8000_0000, 2'd0);
        access("R3", 1'b0, 32'hC000_0040, 2'd2);

        // R4 / R2: misses at region edges
        access("R4", 1'b1, 32'hBFFF_FFFF, 2'd0);
        access("R4", 1'b0, 32'h7FFF_FFFF, 2'd2);
        access("R7", 1'b1, 32'h7FFF_F000, 2'd1);

        // R12: invalidate the lower duplicate, higher one takes over
        load(2, 1'b0, 20'h00020, 20'h55555, 3'b111);
        access("R12", 1'b0, 32'h0002_0123, 2'd0);
        load(0, 1'b1, 20'h00010, 20'h0BEEF, 3'b100);
        access("R12", 1'b0, 32'h0001_0ABC, 2'd2);

        // R7: new base kept across a later translation fault
        set_base(10'h155);
        access("R7", 1'b0, 32'h0003_3000, 2'd0);

        // R9: back-to-back then idle
        access("R9", 1'b0, 32'h0001_0000, 2'd2);
        access("R9", 1'b1, 32'hD000_0000, 2'd0);
        access("R9", 1'b0, 32'hA000_0000, 2'd1);
        idle("R9");
        idle("R9");

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule